// File: doc/BRIEF.md
# SPI EEPROM Protection Command Controller

This block is the slave-side control logic of a serial EEPROM with a 32K x 8 array. It sits behind an SPI mode 0 link made of chip select, serial clock, data in and data out. All four link pins are brought into a fast system clock through two-flop synchronisers, and the block works on the detected edges. It decodes the instruction byte and keeps a status register. That register holds a write enable latch and a two-bit block protect field. The block also enforces every rule that guards the array against an accidental change.

Array traffic goes through a plain request port to an external memory model. A read request returns its data on the following clock. Write data is gathered in a small buffer while the device is selected. The buffered bytes go to the memory port only after the instruction has been accepted on the rising edge of chip select. Status changes wait for that same acceptance point. The array itself, its write timing and page wrap belong to the memory model.

Top module: `eep_prot_ctrl`

## Requirements
- R1: After reset the write enable latch and both protect bits are 0, `spi_miso` is 0, and no memory request is issued.
- R2: Instruction 06h sets the write enable latch and instruction 04h clears it. Both take effect when chip select rises.
- R3: An instruction that changes state (06h, 04h, 01h, 02h) takes effect only if the number of serial clock rising edges while selected is a nonzero multiple of 8. Any other count discards it and leaves the latch, the protect bits and the array untouched.
- R4: Instruction 01h with the latch set and `wp_n` high loads the protect bits from bits [3:2] of its first data byte and clears the latch. With the latch clear it has no effect.
- R5: While `wp_n` is low, instruction 01h leaves the protect bits unchanged. It still clears the latch when the latch is set.
- R6: Instruction 05h shifts out the status byte {0,0,0,0,BP1,BP0,WEL,0} MSB first, repeating it for as long as clocks continue.
- R7: Protect code {BP1,BP0} selects the locked range: 00 none, 01 6000h-7FFFh, 10 4000h-7FFFh, 11 the whole array. A data byte whose address is locked is never written.
- R8: Instruction 02h takes a 16-bit address, MSB first, with bit 15 ignored. Its data bytes are written to consecutive addresses that wrap from 7FFFh to 0000h, one write per clock. Writes start only after chip select has risen. An accepted write clears the latch.
- R9: Instruction 02h issued while the latch is clear writes nothing.
- R10: Instruction 03h takes a 16-bit address with bit 15 ignored. It streams bytes MSB first, driven after each falling clock edge, and the address increments and wraps from 7FFFh to 0000h. The read may end at any bit.
- R11: An unrecognised opcode changes neither the status register nor the array until chip select rises.
- R12: Only the first DEPTH (16) data bytes of a write are kept. Any later bytes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| wp_n | input | 1 | Active-low lock of the protect bits |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 15 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the clock after a read request |

## Verification
Every pin edge reaches the logic three system clocks after it changes. A status change therefore shows about four clocks after chip select rises, and buffered writes issue one per clock right after that. The bench waits forty clocks after each deselect before it reads the write log or issues the next status read, so both results are always settled when they are checked. Read data is due at most four clocks after the falling serial edge that asks for it. The bench samples `spi_miso` six clocks after each falling edge, just before the next rising edge.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_WREN, CMD_WRDI, CMD_RDSR, CMD_WRSR, CMD_READ, CMD_WRITE
  } cmd_e;

  function automatic cmd_e eep_decode(input logic [7:0] op);
    case (op)
      OP_WREN:  return CMD_WREN;
      OP_WRDI:  return CMD_WRDI;
      OP_RDSR:  return CMD_RDSR;
      OP_WRSR:  return CMD_WRSR;
      OP_READ:  return CMD_READ;
      OP_WRITE: return CMD_WRITE;
      default:  return CMD_NONE;
    endcase
  endfunction

  // top2: the two most significant address bits
  function automatic logic eep_locked(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] eep_status_byte(input logic [1:0] bp, input logic wel);
    return {4'b0000, bp, wel, 1'b0};
  endfunction

endpackage

// File: rtl/eep_spi_front.sv
module eep_spi_front #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             cs_n_i,
  input  logic             mosi_i,
  input  logic             wp_n_i,
  output logic             sel,
  output logic             cs_rise,
  output logic             sclk_fall,
  output logic             byte_done,
  output logic [7:0]       byte_val,
  output logic [2:0]       bit_pos,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             wp_s
);

  logic [2:0] sclk_s;
  logic [2:0] cs_s;
  logic [1:0] mosi_s;
  logic [1:0] wp_q;
  logic [6:0] sh;
  logic       sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
      wp_q   <= '1;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk_i};
      cs_s   <= {cs_s[1:0], cs_n_i};
      mosi_s <= {mosi_s[0], mosi_i};
      wp_q   <= {wp_q[0], wp_n_i};
    end
  end

  assign sel       = !cs_s[1];
  assign cs_rise   = cs_s[1] && !cs_s[2];
  assign sclk_rise = sel && sclk_s[1] && !sclk_s[2];
  assign sclk_fall = sel && !sclk_s[1] && sclk_s[2];
  assign wp_s      = wp_q[1];
  assign byte_val  = {sh, mosi_s[1]};
  assign byte_done = sclk_rise && (bit_pos == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      bit_pos  <= '0;
      byte_cnt <= '0;
    end else if (!sel) begin
      bit_pos  <= '0;
      byte_cnt <= '0;
    end else if (sclk_rise) begin
      sh      <= byte_val[6:0];
      bit_pos <= bit_pos + 3'd1;
      if (bit_pos == 3'd7 && byte_cnt != '1)
        byte_cnt <= byte_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/eep_status.sv
module eep_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       bp_we,
  input  logic [1:0] bp_in,
  output logic       wel,
  output logic [1:0] bp
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
      bp  <= 2'b00;
    end else begin
      if (set_wel)      wel <= 1'b1;
      else if (clr_wel) wel <= 1'b0;
      if (bp_we)        bp  <= bp_in;
    end
  end

endmodule

// File: rtl/eep_wbuf.sv
module eep_wbuf
  import eep_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [7:0]        st_data,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CW-1:0]     start_cnt,
  input  logic [1:0]        bp,
  output logic              busy,
  output logic              com_req,
  output logic [ADDR_W-1:0] com_addr,
  output logic [7:0]        com_data
);

  logic [7:0]        buf_q [DEPTH];
  logic [CW-1:0]     left;
  logic [IDX_W-1:0]  rd_idx;
  logic [ADDR_W-1:0] cur;

  always_ff @(posedge clk) begin
    if (st_we) buf_q[st_idx] <= st_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left   <= '0;
      rd_idx <= '0;
      cur    <= '0;
    end else if (start) begin
      left   <= start_cnt;
      rd_idx <= '0;
      cur    <= start_addr;
    end else if (busy) begin
      left   <= left - 1'b1;
      rd_idx <= rd_idx + 1'b1;
      cur    <= cur + 1'b1;
    end
  end

  assign busy     = (left != '0);
  assign com_req  = busy && !eep_locked(bp, cur[ADDR_W-1 -: 2]);
  assign com_addr = cur;
  assign com_data = buf_q[rd_idx];

endmodule

// File: rtl/eep_prot_ctrl.sv
module eep_prot_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              wp_n,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int CNT_W = $clog2(DEPTH + 8) + 1;

  logic             sel, cs_rise, sclk_fall, byte_done, wp_s;
  logic [7:0]       byte_val;
  logic [2:0]       bit_pos;
  logic [CNT_W-1:0] byte_cnt;

  eep_spi_front #(.CNT_W(CNT_W)) u_front (
    .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n),
    .mosi_i(spi_mosi), .wp_n_i(wp_n), .sel(sel), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .byte_done(byte_done), .byte_val(byte_val),
    .bit_pos(bit_pos), .byte_cnt(byte_cnt), .wp_s(wp_s)
  );

  // decode state, held for the selected window
  cmd_e              cmd_q;
  logic [ADDR_W-9:0] a_hi_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        sr_bp_q;
  logic [ADDR_W-1:0] addr_full;
  logic [CNT_W-1:0]  n_data;

  assign addr_full = {a_hi_q, byte_val};
  assign n_data    = byte_cnt - CNT_W'(3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= CMD_NONE;
      a_hi_q  <= '0;
      base_q  <= '0;
      sr_bp_q <= '0;
    end else if (!sel) begin
      cmd_q <= CMD_NONE;
    end else if (byte_done) begin
      if (byte_cnt == CNT_W'(0)) cmd_q <= eep_decode(byte_val);
      if (byte_cnt == CNT_W'(1)) begin
        a_hi_q <= byte_val[ADDR_W-9:0];
        if (cmd_q == CMD_WRSR) sr_bp_q <= byte_val[3:2];
      end
      if (byte_cnt == CNT_W'(2)) base_q <= addr_full;
    end
  end

  // acceptance events
  logic       wel;
  logic [1:0] bp;
  logic       aligned, wren_ok, wrdi_ok, wrsr_ok, write_ok;

  assign aligned  = (bit_pos == 3'd0);
  assign wren_ok  = cs_rise && aligned && cmd_q == CMD_WREN;
  assign wrdi_ok  = cs_rise && aligned && cmd_q == CMD_WRDI;
  assign wrsr_ok  = cs_rise && aligned && cmd_q == CMD_WRSR
                    && byte_cnt >= CNT_W'(2) && wel;
  assign write_ok = cs_rise && aligned && cmd_q == CMD_WRITE
                    && byte_cnt >= CNT_W'(4) && wel;

  eep_status u_status (
    .clk(clk), .rst_n(rst_n), .set_wel(wren_ok),
    .clr_wel(wrdi_ok || wrsr_ok || write_ok),
    .bp_we(wrsr_ok && wp_s), .bp_in(sr_bp_q), .wel(wel), .bp(bp)
  );

  // write buffer and commit
  logic              st_we, com_busy, com_req;
  logic [CW-1:0]     start_cnt;
  logic [ADDR_W-1:0] com_addr;
  logic [7:0]        com_data;

  assign st_we     = byte_done && cmd_q == CMD_WRITE && byte_cnt >= CNT_W'(3)
                     && n_data < CNT_W'(DEPTH);
  assign start_cnt = (n_data > CNT_W'(DEPTH)) ? CW'(DEPTH) : n_data[CW-1:0];

  eep_wbuf #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .st_we(st_we), .st_idx(n_data[IDX_W-1:0]),
    .st_data(byte_val), .start(write_ok), .start_addr(base_q),
    .start_cnt(start_cnt), .bp(bp), .busy(com_busy), .com_req(com_req),
    .com_addr(com_addr), .com_data(com_data)
  );

  // read and status output path
  logic              fetch_q, cap_q;
  logic [ADDR_W-1:0] fetch_addr, rd_next;
  logic [7:0]        tx_next, tx_sr;
  logic              rdsr_load, read_load, read_start;

  assign rdsr_load  = cmd_q == CMD_RDSR && aligned && byte_cnt != '0;
  assign read_load  = cmd_q == CMD_READ && aligned && byte_cnt >= CNT_W'(3);
  assign read_start = byte_done && byte_cnt == CNT_W'(2) && cmd_q == CMD_READ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q    <= 1'b0;
      cap_q      <= 1'b0;
      fetch_addr <= '0;
      rd_next    <= '0;
      tx_next    <= '0;
      tx_sr      <= '0;
    end else begin
      fetch_q <= 1'b0;
      cap_q   <= fetch_q;
      if (cap_q) tx_next <= mem_rdata;
      if (!sel) begin
        tx_sr <= '0;
      end else if (sclk_fall) begin
        if (rdsr_load) begin
          tx_sr <= eep_status_byte(bp, wel);
        end else if (read_load) begin
          tx_sr      <= tx_next;
          fetch_q    <= 1'b1;
          fetch_addr <= rd_next;
          rd_next    <= rd_next + 1'b1;
        end else begin
          tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
      if (read_start) begin
        fetch_q    <= 1'b1;
        fetch_addr <= addr_full;
        rd_next    <= addr_full + 1'b1;
      end
    end
  end

  assign spi_miso  = tx_sr[7];
  assign mem_req   = com_req || fetch_q;
  assign mem_we    = com_req;
  assign mem_addr  = com_req ? com_addr : fetch_addr;
  assign mem_wdata = com_data;

endmodule

// File: rtl/eep_prot_chk.sv
module eep_prot_chk
  import eep_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              wel,
  input logic [1:0]        bp,
  input logic              wp_s,
  input logic              aligned,
  input logic              wren_ok,
  input logic              wrdi_ok,
  input logic              wrsr_ok,
  input logic              write_ok,
  input logic              com_busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);

  // R2
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(wren_ok));

  // R3
  commit_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(com_busy) |-> $past(aligned && write_ok));

  // R4
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel) |-> $past(wrdi_ok || wrsr_ok || write_ok));

  // R5
  bp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $past(wrsr_ok && wp_s));

  // R7
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !eep_locked(bp, mem_addr[ADDR_W-1 -: 2]));

  // R8
  write_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !sel);

  // R10
  read_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> sel);

endmodule

bind eep_prot_ctrl eep_prot_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wel(wel), .bp(bp), .wp_s(wp_s),
  .aligned(aligned), .wren_ok(wren_ok), .wrdi_ok(wrdi_ok), .wrsr_ok(wrsr_ok),
  .write_ok(write_ok), .com_busy(com_busy), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/eep_prot_ctrl_test.sv
module eep_prot_ctrl_test;

  localparam int HALF = 6;

  logic clk = 0, rst_n = 0;
  logic spi_cs_n = 1, spi_sclk = 0, spi_mosi = 0, wp_n = 1;
  logic spi_miso, mem_req, mem_we;
  logic [14:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  eep_prot_ctrl uut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .wp_n(wp_n), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  int vectors = 0, miscompares = 0;
  int wr_n = 0, wr_before = 0, any_req = 0;
  logic [14:0] lg_a [0:31];
  logic [7:0]  lg_d [0:31];
  logic [7:0]  tx_buf [0:23];
  logic [7:0]  rx_buf [0:23];
  logic [1:0]  bp_m = 2'b00;

  function automatic logic [7:0] pat(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  function automatic bit prot(input logic [1:0] b, input logic [14:0] a);
    int v = int'(a);
    if (b == 2'd1) return v >= 'h6000;
    if (b == 2'd2) return v >= 'h4000;
    return b == 2'd3;
  endfunction

  // memory model
  always @(posedge clk) begin
    if (mem_req) begin
      any_req <= any_req + 1;
      if (mem_we) begin
        if (wr_n < 32) begin
          lg_a[wr_n] <= mem_addr;
          lg_d[wr_n] <= mem_wdata;
        end
        wr_n <= wr_n + 1;
      end else begin
        mem_rdata <= pat(mem_addr);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic spi_run(input int nbits);
    @(negedge clk) spi_cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = tx_buf[i / 8][7 - (i % 8)];
      repeat (HALF) @(negedge clk);
      rx_buf[i / 8][7 - (i % 8)] = spi_miso;
      spi_sclk = 1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 0;
    end
    repeat (HALF) @(negedge clk);
    wr_before = wr_n;
    spi_cs_n = 1;
    repeat (40) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op, input int nbits);
    tx_buf[0] = op;
    spi_run(nbits);
  endtask

  task automatic rdsr(output logic [7:0] sr);
    tx_buf[0] = 8'h05; tx_buf[1] = 0; tx_buf[2] = 0;
    spi_run(24);
    sr = rx_buf[1];
    chk("R6 status repeats", int'(rx_buf[2]), int'(rx_buf[1]));
  endtask

  task automatic set_bp(input logic [1:0] b);
    cmd1(8'h06, 8);
    tx_buf[0] = 8'h01; tx_buf[1] = {4'b0, b, 2'b11};
    spi_run(16);
    bp_m = b;
  endtask

  task automatic wr_test(input logic [15:0] a, input int n, input logic [7:0] base,
                         input bit en, input int extra, input bit expect_ok, input string tag);
    int j, m;
    logic [14:0] ea;
    if (en) cmd1(8'h06, 8);
    wr_n = 0;
    tx_buf[0] = 8'h02; tx_buf[1] = a[15:8]; tx_buf[2] = a[7:0];
    for (int k = 0; k < n && k < 21; k++) tx_buf[3 + k] = base + 8'(k * 7);
    spi_run(8 * (3 + n) + extra);
    chk({tag, " R8 no write before deselect"}, wr_before, 0);
    j = 0;
    m = (n < 16) ? n : 16;
    if (expect_ok) begin
      for (int k = 0; k < m; k++) begin
        ea = a[14:0] + 15'(k);
        if (!prot(bp_m, ea)) begin
          chk({tag, " addr"}, int'(lg_a[j]), int'(ea));
          chk({tag, " data"}, int'(lg_d[j]), int'(base + 8'(k * 7)));
          j++;
        end
      end
    end
    chk({tag, " write count"}, wr_n, j);
  endtask

  logic [7:0] sr;

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 miso after reset", int'(spi_miso), 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    chk("R1 no request", any_req, 0);
    rdsr(sr);
    chk("R1 status after reset", int'(sr), 'h00);

    // R2
    cmd1(8'h06, 8); rdsr(sr); chk("R2 latch set", int'(sr), 'h02);
    cmd1(8'h04, 8); rdsr(sr); chk("R2 latch cleared", int'(sr), 'h00);

    // R3 misaligned deselect
    tx_buf[1] = 0;
    cmd1(8'h06, 9); rdsr(sr); chk("R3 9-bit enable discarded", int'(sr), 'h00);
    cmd1(8'h06, 7); rdsr(sr); chk("R3 7-bit enable discarded", int'(sr), 'h00);

    // R11 unknown opcode
    cmd1(8'h06, 8);
    tx_buf[1] = 8'h0C;
    cmd1(8'hA5, 16); rdsr(sr); chk("R11 unknown opcode no effect", int'(sr), 'h02);
    chk("R11 no request", any_req, 0);
    cmd1(8'h04, 8);

    // R4
    tx_buf[0] = 8'h01; tx_buf[1] = 8'h0C; spi_run(16);
    rdsr(sr); chk("R4 status write without latch", int'(sr), 'h00);
    set_bp(2'b11); rdsr(sr); chk("R4 protect written, latch cleared", int'(sr), 'h0C);
    cmd1(8'h06, 8);
    tx_buf[0] = 8'h01; tx_buf[1] = 8'h00; spi_run(12);
    rdsr(sr); chk("R3 misaligned status write", int'(sr), 'h0E);
    cmd1(8'h04, 8);

    // R5
    wp_n = 0;
    cmd1(8'h06, 8);
    tx_buf[0] = 8'h01; tx_buf[1] = 8'h00; spi_run(16);
    rdsr(sr); chk("R5 protect held while wp_n low", int'(sr), 'h0C);
    wp_n = 1;

    // R7 sweep over protect codes and addresses
    for (int b = 0; b < 4; b++) begin
      set_bp(2'(b));
      rdsr(sr); chk("R7 protect code readback", int'(sr), b * 4);
      wr_test(16'h0000, 1, 8'h11, 1, 0, 1, "R7 0000h");
      wr_test(16'h3FFF, 1, 8'h22, 1, 0, 1, "R7 3FFFh");
      wr_test(16'h4000, 1, 8'h33, 1, 0, 1, "R7 4000h");
      wr_test(16'h5FFF, 1, 8'h44, 1, 0, 1, "R7 5FFFh");
      wr_test(16'h6000, 1, 8'h55, 1, 0, 1, "R7 6000h");
      wr_test(16'hFFFF, 1, 8'h66, 1, 0, 1, "R8 bit15 ignored 7FFFh");
      wr_test(16'hA000, 1, 8'h77, 1, 0, 1, "R8 bit15 ignored 2000h");
    end
    rdsr(sr); chk("R8 latch cleared by write", int'(sr), 'h0C);

    set_bp(2'b00);
    wr_test(16'h7FFD, 5, 8'h80, 1, 0, 1, "R8 wrap");
    wr_test(16'h1234, 2, 8'h01, 0, 0, 0, "R9 no latch");
    wr_test(16'h1234, 2, 8'h01, 1, 4, 0, "R3 misaligned write");
    rdsr(sr); chk("R3 latch kept after discarded write", int'(sr), 'h02);
    wr_test(16'h0100, 20, 8'h09, 0, 0, 1, "R12 depth limit");
    set_bp(2'b01);
    wr_test(16'h5FFE, 4, 8'hC0, 1, 0, 1, "R7 straddle 6000h");

    // R10 reads
    tx_buf[0] = 8'h03; tx_buf[1] = 8'h7F; tx_buf[2] = 8'hFE;
    spi_run(8 * 7 + 3);
    for (int k = 0; k < 4; k++)
      chk("R10 read wrap", int'(rx_buf[3 + k]), int'(pat(15'h7FFE + 15'(k))));
    tx_buf[0] = 8'h03; tx_buf[1] = 8'h80; tx_buf[2] = 8'h10;
    spi_run(8 * 5);
    chk("R10 read bit15 ignored", int'(rx_buf[3]), int'(pat(15'h0010)));
    chk("R10 read increment", int'(rx_buf[4]), int'(pat(15'h0011)));

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule